// File: doc/BRIEF.md
# Dual-Channel Serial ADC Reader

This block reads two conversion results from a 12-bit serial converter over three wires: an active-low chip select, a serial clock, and one shared data line that first carries a command out of the block and then carries the result back in. A single `start` pulse runs two frames back to back. The first frame uses command `1101` and the second uses command `1111`. In each frame the block sends the 4-bit command and gives up the data line. It then clocks in one null bit followed by twelve result bits. When the second frame ends, both results appear on the outputs in the same cycle, and `done` pulses for one cycle.

The block does not contain the tri-state pad. It provides a data-out value, an output enable and a data-in input, and the level above builds the pad from them. The serial clock comes from the system clock through a tick divider, so every serial low or high phase lasts exactly `DIV` system cycles.

The sequencer has seven named states. IDLE waits for `start` and then moves to CS_WAIT. CS_WAIT keeps chip select high for `IDLE_PHASES` ticks and then moves to CMD_LO. CMD_LO drives a command bit with the clock low and moves to CMD_HI. CMD_HI raises the clock; it returns to CMD_LO for the next command bit, or moves to RD_LO after the fourth bit. RD_LO keeps the clock low with the data line released, samples the data line at the end of the phase and moves to RD_HI. RD_HI returns to RD_LO for the next bit, or moves to TAIL after the thirteenth bit. TAIL holds the clock low for one phase and then raises chip select. From TAIL the block goes to CS_WAIT for channel 1, or to IDLE with a commit after channel 1.

Top module: `dual_adc_reader`

## Requirements
- R1: While the block is in reset or idle, `adc_cs_n`=1, `adc_sclk`=0, `adc_oe`=0, `busy`=0 and `done`=0.
- R2: Before each falling edge of `adc_cs_n`, chip select stays high for at least `IDLE_PHASES*DIV` system cycles.
- R3: The first frame after `start` shifts out command 1101 and the second shifts out 1111. Bits go out MSB first, one per rising edge of `adc_sclk`, with `adc_oe`=1 at each of these four edges.
- R4: While `adc_cs_n` is low, each low and each high phase of `adc_sclk` lasts exactly `DIV` system cycles, and `adc_sclk` is never high while `adc_cs_n` is high.
- R5: After the fourth command edge, `adc_oe` is 0 at every later rising edge of the frame. `adc_oe` is never 1 while `adc_cs_n` is high.
- R6: Each frame has exactly 17 rising edges of `adc_sclk`: 4 for the command and 13 for the input. Input bits are sampled while the clock is low, before the rising edge that follows them.
- R7: Of the 13 input bits, the first (null) bit is discarded and the next 12 form the result, MSB first. The high output holds result bits 11:8 and the low output holds bits 7:0, whatever value the null bit has.
- R8: `adc_cs_n` returns high after the last input bit of each frame. A `start` produces exactly two frames, channel 0 then channel 1, and the second begins only after the first ends.
- R9: All four result outputs change only in the cycle in which `done` is 1. `done` is a one-cycle pulse that occurs when the channel 1 frame ends.
- R10: A `start` pulse that arrives while `busy`=1 has no effect: it causes no extra frames and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a two-channel read when idle |
| adc_din | input | 1 | Data line value coming from the pad |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles low |
| adc_dout | output | 1 | Command bit to drive on the data line |
| adc_oe | output | 1 | Pad output enable for the data line |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse: both results updated |
| ch0_hi | output | 4 | Channel 0 result bits 11:8 |
| ch0_lo | output | 8 | Channel 0 result bits 7:0 |
| ch1_hi | output | 4 | Channel 1 result bits 11:8 |
| ch1_lo | output | 8 | Channel 1 result bits 7:0 |

## Verification
A converter model in the bench returns all-ones, all-zero, single-bit-boundary and random results, and drives a null bit of either polarity. Each case catches a different fault:
- If the null bit is not masked, the high nibble is wrong.
- If the sampling is off by one, every result comes back shifted.
- If the command order or bit order is swapped, the model returns the wrong channel's value.
- If the bit counting is wrong, the model sees a rising-edge count other than 17.

The bench also measures the length of every clock phase and of every chip-select gap, and checks that `adc_oe` is released at the turnaround. It injects a second `start` in the middle of a read; a design that accepted it would show a third frame or a second `done`.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int CMD_W   = 4;
    localparam int RES_W   = 12;
    localparam int HI_W    = 4;
    localparam int LO_W    = RES_W - HI_W;
    localparam int RD_BITS = RES_W + 1;

    localparam logic [CMD_W-1:0] CMD_CH0 = 4'b1101;
    localparam logic [CMD_W-1:0] CMD_CH1 = 4'b1111;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CS_WAIT,
        S_CMD_LO,
        S_CMD_HI,
        S_RD_LO,
        S_RD_HI,
        S_TAIL
    } seq_state_t;

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en || cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == LAST);

    // R4: the divider restarts from zero whenever it is disabled
    assert_tick_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_rd_pkg::*;
#(
    parameter int IDLE_PHASES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             din,
    output logic             busy,
    output logic             cs_n,
    output logic             sclk,
    output logic             dout,
    output logic             oe,
    output logic             commit,
    output logic [RES_W-1:0] res0,
    output logic [RES_W-1:0] res1
);
    localparam int CMAX = (IDLE_PHASES > RD_BITS) ? IDLE_PHASES : RD_BITS;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] IDLE_LAST = CW'(IDLE_PHASES - 1);
    localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_W - 1);
    localparam logic [CW-1:0] RD_LAST   = CW'(RD_BITS - 1);

    seq_state_t         state_q, state_d;
    logic               ch_q, ch_d;
    logic [CW-1:0]      cnt_q, cnt_d;
    logic [RD_BITS-1:0] sh_q, sh_d;
    logic [RES_W-1:0]   hold_q, hold_d;

    // next state and datapath
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        hold_d  = hold_q;
        commit  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_CS_WAIT;
                    ch_d    = 1'b0;
                    cnt_d   = '0;
                end
            end
            S_CS_WAIT: begin
                if (tick) begin
                    if (cnt_q == IDLE_LAST) begin
                        state_d = S_CMD_LO;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            S_CMD_LO: begin
                if (tick) state_d = S_CMD_HI;
            end
            S_CMD_HI: begin
                if (tick) begin
                    if (cnt_q == CMD_LAST) begin
                        state_d = S_RD_LO;
                        cnt_d   = '0;
                    end else begin
                        state_d = S_CMD_LO;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            S_RD_LO: begin
                if (tick) begin
                    sh_d    = {sh_q[RD_BITS-2:0], din};
                    state_d = S_RD_HI;
                end
            end
            S_RD_HI: begin
                if (tick) begin
                    if (cnt_q == RD_LAST) begin
                        state_d = S_TAIL;
                        cnt_d   = '0;
                    end else begin
                        state_d = S_RD_LO;
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
            end
            S_TAIL: begin
                if (tick) begin
                    cnt_d = '0;
                    if (!ch_q) begin
                        hold_d  = sh_q[RES_W-1:0];
                        ch_d    = 1'b1;
                        state_d = S_CS_WAIT;
                    end else begin
                        commit  = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= 1'b0;
            cnt_q   <= '0;
            sh_q    <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            hold_q  <= hold_d;
        end
    end

    // outputs
    always_comb begin
        logic [CMD_W-1:0] cmd;
        cmd  = ch_q ? CMD_CH1 : CMD_CH0;
        busy = (state_q != S_IDLE);
        cs_n = (state_q == S_IDLE) || (state_q == S_CS_WAIT);
        sclk = (state_q == S_CMD_HI) || (state_q == S_RD_HI);
        oe   = (state_q == S_CMD_LO) || (state_q == S_CMD_HI);
        dout = oe ? cmd[CMD_LAST - cnt_q[$clog2(CMD_W)-1:0]] : 1'b0;
    end

    assign res0 = hold_q;
    assign res1 = sh_q[RES_W-1:0];

    assert_oe_inside_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !cs_n);
    assert_sclk_inside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    assert_phase_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sclk));
    assert_ch1_follows_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAIL && tick && !ch_q) |=> (state_q == S_CS_WAIT && ch_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [RES_W-1:0] res0,
    input  logic [RES_W-1:0] res1,
    output logic             done,
    output logic [HI_W-1:0]  ch0_hi,
    output logic [LO_W-1:0]  ch0_lo,
    output logic [HI_W-1:0]  ch1_hi,
    output logic [LO_W-1:0]  ch1_lo
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            ch0_hi <= '0;
            ch0_lo <= '0;
            ch1_hi <= '0;
            ch1_lo <= '0;
        end else begin
            done <= commit;
            if (commit) begin
                ch0_hi <= res0[RES_W-1:LO_W];
                ch0_lo <= res0[LO_W-1:0];
                ch1_hi <= res1[RES_W-1:LO_W];
                ch1_lo <= res1[LO_W-1:0];
            end
        end
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV         = 4,
    parameter int IDLE_PHASES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            adc_din,
    output logic            adc_cs_n,
    output logic            adc_sclk,
    output logic            adc_dout,
    output logic            adc_oe,
    output logic            busy,
    output logic            done,
    output logic [HI_W-1:0] ch0_hi,
    output logic [LO_W-1:0] ch0_lo,
    output logic [HI_W-1:0] ch1_hi,
    output logic [LO_W-1:0] ch1_lo
);
    logic             tick;
    logic             commit;
    logic [RES_W-1:0] res0, res1;

    adc_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    adc_seq_fsm #(.IDLE_PHASES(IDLE_PHASES)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .tick  (tick),
        .din   (adc_din),
        .busy  (busy),
        .cs_n  (adc_cs_n),
        .sclk  (adc_sclk),
        .dout  (adc_dout),
        .oe    (adc_oe),
        .commit(commit),
        .res0  (res0),
        .res1  (res1)
    );

    adc_result_bank u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit),
        .res0  (res0),
        .res1  (res1),
        .done  (done),
        .ch0_hi(ch0_hi),
        .ch0_lo(ch0_lo),
        .ch1_hi(ch1_hi),
        .ch1_lo(ch1_lo)
    );

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (adc_cs_n && !adc_sclk && !adc_oe));
    assert_results_only_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({ch0_hi, ch0_lo, ch1_hi, ch1_lo}));
endmodule

// File: tb/dual_adc_reader_tb.sv
module dual_adc_reader_tb;
    localparam int DIV = 4;
    localparam int IDLE_PHASES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic adc_din;
    logic adc_cs_n, adc_sclk, adc_dout, adc_oe, busy, done;
    logic [3:0] ch0_hi, ch1_hi;
    logic [7:0] ch0_lo, ch1_lo;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dual_adc_reader #(.DIV(DIV), .IDLE_PHASES(IDLE_PHASES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .adc_din(adc_din),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_dout(adc_dout),
        .adc_oe(adc_oe), .busy(busy), .done(done),
        .ch0_hi(ch0_hi), .ch0_lo(ch0_lo), .ch1_hi(ch1_hi), .ch1_lo(ch1_lo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_hi(input logic [11:0] v);
        return v[11:8];
    endfunction
    function automatic logic [7:0] exp_lo(input logic [11:0] v);
        return v[7:0];
    endfunction

    // converter model
    logic [11:0] m_val0, m_val1, m_cur;
    logic        m_null;
    logic [3:0]  m_cmd;
    int          m_edges;
    int          frames;
    int          oe_err;
    int          dout_err;
    logic [3:0]  cmd_log [2];
    int          edge_log [2];

    initial begin
        adc_din = 1'b0;
        m_edges = 0;
        m_cmd = '0;
        m_cur = '0;
        frames = 0;
        oe_err = 0;
        dout_err = 0;
    end

    always @(negedge adc_cs_n) begin
        m_edges = 0;
        m_cmd = '0;
    end

    always @(posedge adc_cs_n) begin
        if (rst_n) begin
            if (frames < 2) edge_log[frames] = m_edges;
            frames++;
        end
    end

    always @(posedge adc_sclk) begin
        if (!adc_cs_n) begin
            if (m_edges < 4) begin
                if (!adc_oe) oe_err++;
                m_cmd = {m_cmd[2:0], adc_dout};
                if (m_edges == 3) begin
                    if (frames < 2) cmd_log[frames] = m_cmd;
                    m_cur = (m_cmd == 4'b1101) ? m_val0 :
                            (m_cmd == 4'b1111) ? m_val1 : 12'h000;
                    adc_din = m_null;
                end
            end else begin
                if (adc_oe) oe_err++;
                if (m_edges - 4 < 12) adc_din = m_cur[11 - (m_edges - 4)];
                else adc_din = ~m_null;
            end
            m_edges++;
        end
    end

    // phase and gap measurement
    int run_len = 0;
    int min_run = 1000000, max_run = 0;
    int gap_len = 0;
    int min_gap = 1000000;
    logic prev_sclk = 1'b0;
    logic prev_cs = 1'b1;
    int done_seen = 0;

    always @(negedge clk) begin
        if (done) done_seen++;
        if (adc_cs_n) begin
            run_len = 0;
            if (busy) gap_len++;
        end else begin
            if (prev_cs && rst_n) begin
                if (gap_len < min_gap) min_gap = gap_len;
                gap_len = 0;
            end
            if (run_len == 0) run_len = 1;
            else if (adc_sclk != prev_sclk) begin
                if (run_len < min_run) min_run = run_len;
                if (run_len > max_run) max_run = run_len;
                run_len = 1;
            end else run_len++;
        end
        prev_sclk = adc_sclk;
        prev_cs = adc_cs_n;
    end

    logic [11:0] last0 = '0, last1 = '0;

    task automatic run_pair(input logic [11:0] v0, input logic [11:0] v1,
                            input logic nb, input bit extra_start);
        int t;
        int done_before;
        m_val0 = v0;
        m_val1 = v1;
        m_null = nb;
        frames = 0;
        oe_err = 0;
        min_gap = 1000000;
        gap_len = 0;
        cmd_log[0] = '0; cmd_log[1] = '0;
        edge_log[0] = 0; edge_log[1] = 0;
        done_before = done_seen;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (100) @(negedge clk);
        // R9: outputs still hold the previous results mid-read
        check({ch0_hi, ch0_lo, ch1_hi, ch1_lo} == {exp_hi(last0), exp_lo(last0), exp_hi(last1), exp_lo(last1)},
              "R9 hold", {ch0_hi, ch0_lo, ch1_hi, ch1_lo}, {last0, last1});
        if (extra_start) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done, "R9 done seen", done, 1);
        check(ch0_hi == exp_hi(v0), "R7 ch0_hi", ch0_hi, exp_hi(v0));
        check(ch0_lo == exp_lo(v0), "R7 ch0_lo", ch0_lo, exp_lo(v0));
        check(ch1_hi == exp_hi(v1), "R7 ch1_hi", ch1_hi, exp_hi(v1));
        check(ch1_lo == exp_lo(v1), "R7 ch1_lo", ch1_lo, exp_lo(v1));
        check(cmd_log[0] == 4'b1101, "R3 cmd ch0", cmd_log[0], 4'b1101);
        check(cmd_log[1] == 4'b1111, "R3 cmd ch1", cmd_log[1], 4'b1111);
        check(edge_log[0] == 17, "R6 edges ch0", edge_log[0], 17);
        check(edge_log[1] == 17, "R6 edges ch1", edge_log[1], 17);
        check(oe_err == 0, "R5 oe at edges", oe_err, 0);
        check(min_gap >= IDLE_PHASES * DIV, "R2 cs gap", min_gap, IDLE_PHASES * DIV);
        @(negedge clk);
        check(!done, "R9 pulse width", done, 0);
        repeat (extra_start ? 400 : 5) @(negedge clk);
        check(frames == 2, "R8 frame count", frames, 2);
        check(done_seen - done_before == 1, "R10 done count", done_seen - done_before, 1);
        check(!busy && adc_cs_n, "R8 back idle", {busy, adc_cs_n}, 2'b01);
        last0 = v0;
        last1 = v1;
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
        check(adc_sclk == 1'b0, "R1 sclk", adc_sclk, 0);
        check(adc_oe == 1'b0, "R1 oe", adc_oe, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(adc_cs_n && !adc_sclk && !adc_oe, "R1 idle lines", {adc_cs_n, adc_sclk, adc_oe}, 3'b100);

        run_pair(12'hFFF, 12'h000, 1'b1, 1'b0);
        run_pair(12'h000, 12'hFFF, 1'b0, 1'b0);
        run_pair(12'h800, 12'h001, 1'b1, 1'b1);   // R10 extra start while busy
        run_pair(12'h0FF, 12'hF00, 1'b1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            run_pair(12'($urandom), 12'($urandom), 1'($urandom), (i == 3));
        end
        // R4: every measured phase is DIV cycles
        check(min_run == DIV, "R4 min phase", min_run, DIV);
        check(max_run == DIV, "R4 max phase", max_run, DIV);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule